// File: doc/BRIEF.md
# Unlock Command Sequence Decoder

This block sits behind the write port of a two-bank, word-wide flash array and turns the stream of latched write cycles into internal array operations. Each write arrives as a single-cycle strobe that carries the latched address and data. The decoder accepts only unlock-protected commands. Every command opens with two fixed key cycles. A third cycle either finishes a short command or arms a longer one. Word programming takes one extra cycle that carries the target address and data. The erase family takes three more cycles. The final cycle of a sequence selects the bank, so the other bank stays free for reads between strobes.

A completed program or erase leaves the block as a one-cycle request. The request carries the operation kind, the bank, the aligned target address and the data. The decoder also keeps two mode flags, one for identification read and one for erase verify. While identification mode is on, it answers reads of the two identification words in the selected bank. Any unexpected address or data drops the sequence and returns the decoder to plain read. Writes are ignored completely while either bank reports an erase or program in progress.

Top module: `cmdseq_decoder`

## Requirements
- R1: After reset, op_valid, id_mode, ev_mode and id_word are all zero, and the sequencer waits for the first key cycle.
- R2: The sequence AAh@5555h, 55h@2AAAh, A0h@5555h followed by a fourth write produces op_valid in the cycle after that fourth strobe. The request has op_kind 0 (program), op_addr equal to the fourth address, op_data equal to the fourth data, and op_bank set from that address.
- R3: After AAh@5555h, 55h@2AAAh, 80h@5555h, AAh@5555h, 55h@2AAAh, the sixth write selects the operation. 30h is a sector erase: op_kind 1, address bits below bit 10 cleared. 50h is a block erase: op_kind 2, address bits below bit 15 cleared. 10h is a chip erase: op_kind 3, the address must be 5555h, and op_addr is the bank base (C0000h for the upper bank, 0 otherwise). op_bank is 1 only when address bits 19 and 18 are both one.
- R4: Only data bits 7..0 and address bits 14..0 take part in command matching. Bits 15..8 of the data and bits 17..15 of the address have no effect on matching.
- R5: A wrong address or data at any step produces no request and returns to the idle state. The next sequence must begin again with AAh@5555h.
- R6: A strobe while any bank_busy bit is set is ignored. It produces no request and changes neither the sequence position nor the mode flags.
- R7: A third cycle of 90h@5555h sets id_mode and latches id_bank from that address. A third cycle of F0h@5555h clears both id_mode and ev_mode.
- R8: While id_mode is set, third cycles other than F0h abort the sequence and no request is issued.
- R9: One cycle after rd_addr is applied, id_word reads 0062h when id_mode is set, rd_addr lies in the identified bank, and the in-bank offset (bits 17..0) is 0. At offset 1 it reads 257Eh for the upper bank and 257Dh for the lower bank. In every other case it reads 0000h.
- R10: A sixth cycle of B0h@5555h sets ev_mode. Erase sequences are still accepted while ev_mode is set.
- R11: When byte_mode is high at the data cycle of a program, op_data bits 15..8 are zero and bits 7..0 carry the written byte.
- R12: op_valid is high for exactly one cycle per completed sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_stb | input | 1 | One-cycle pulse per latched write cycle |
| wr_addr | input | 20 | Latched word address of the write |
| wr_data | input | 16 | Latched data of the write |
| bank_busy | input | 2 | Erase/program in progress, bit 1 upper bank, bit 0 lower bank |
| byte_mode | input | 1 | Byte-wide bus mode |
| rd_addr | input | 20 | Read address for identification words |
| op_valid | output | 1 | One-cycle operation request |
| op_kind | output | 2 | 0 program, 1 sector erase, 2 block erase, 3 chip erase |
| op_bank | output | 1 | Target bank, 1 = upper |
| op_addr | output | 20 | Target address, aligned for erases |
| op_data | output | 16 | Program data, 0 for erases |
| id_mode | output | 1 | Identification mode active |
| id_bank | output | 1 | Bank selected for identification |
| ev_mode | output | 1 | Erase-verify mode active |
| id_word | output | 16 | Identification read data, registered |

## Verification
The bench builds the block with its default parameters: a 20-bit word address, a 16-bit data path, 15 compared command address bits, and sector and block alignment at bits 10 and 15. These values put both banks within reach through the top two address bits. They also make the ignored address bits 17..15 reachable, so the noisy-address chip erase and the bank-offset identification reads exercise real boundary positions rather than degenerate ones.

// File: rtl/cmdseq_pkg.sv
`timescale 1ns/1ps
package cmdseq_pkg;
  typedef enum logic [2:0] {
    SQ_IDLE, SQ_U1, SQ_U2, SQ_PGM, SQ_E3, SQ_E4, SQ_E5
  } seq_t;

  typedef enum logic [1:0] {
    OP_PROG = 2'd0, OP_SECT = 2'd1, OP_BLK = 2'd2, OP_CHIP = 2'd3
  } op_kind_t;

  localparam logic [7:0] CD_KEY1  = 8'hAA;
  localparam logic [7:0] CD_KEY2  = 8'h55;
  localparam logic [7:0] CD_PROG  = 8'hA0;
  localparam logic [7:0] CD_ERASE = 8'h80;
  localparam logic [7:0] CD_IDENT = 8'h90;
  localparam logic [7:0] CD_EXIT  = 8'hF0;
  localparam logic [7:0] CD_SECT  = 8'h30;
  localparam logic [7:0] CD_BLK   = 8'h50;
  localparam logic [7:0] CD_CHIP  = 8'h10;
  localparam logic [7:0] CD_VFY   = 8'hB0;
endpackage

// File: rtl/cmdseq_match.sv
`timescale 1ns/1ps
module cmdseq_match #(
  parameter int          CMD_AW = 15,
  parameter logic [14:0] KEY1_A = 15'h5555,
  parameter logic [14:0] KEY2_A = 15'h2AAA
) (
  input  logic [CMD_AW-1:0] addr_lo,
  output logic              hit_k1,
  output logic              hit_k2
);
  // only the low command address field is compared
  assign hit_k1 = (addr_lo == CMD_AW'(KEY1_A));
  assign hit_k2 = (addr_lo == CMD_AW'(KEY2_A));
endmodule

// File: rtl/cmdseq_fsm.sv
`timescale 1ns/1ps
module cmdseq_fsm
  import cmdseq_pkg::*;
#(
  parameter int ADDR_W   = 20,
  parameter int DATA_W   = 16,
  parameter int SECT_LSB = 10,
  parameter int BLK_LSB  = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_stb,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              hit_k1,
  input  logic              hit_k2,
  input  logic              busy_any,
  input  logic              byte_mode,
  output logic              op_valid,
  output op_kind_t          op_kind,
  output logic              op_bank,
  output logic [ADDR_W-1:0] op_addr,
  output logic [DATA_W-1:0] op_data,
  output logic              id_mode,
  output logic              id_bank,
  output logic              ev_mode
);
  localparam int BANK_LSB = ADDR_W - 2;

  seq_t       st;
  logic [7:0] code;
  logic       wr_hi;

  assign code  = wr_data[7:0];
  assign wr_hi = &wr_addr[ADDR_W-1:BANK_LSB];

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= SQ_IDLE;
      op_valid <= 1'b0;
      op_kind  <= OP_PROG;
      op_bank  <= 1'b0;
      op_addr  <= '0;
      op_data  <= '0;
      id_mode  <= 1'b0;
      id_bank  <= 1'b0;
      ev_mode  <= 1'b0;
    end else begin
      op_valid <= 1'b0;
      if (wr_stb && !busy_any) begin
        st <= SQ_IDLE;
        case (st)
          SQ_IDLE: if (hit_k1 && code == CD_KEY1) st <= SQ_U1;
          SQ_U1:   if (hit_k2 && code == CD_KEY2) st <= SQ_U2;
          SQ_U2: begin
            if (hit_k1) begin
              if (code == CD_EXIT) begin
                id_mode <= 1'b0;
                ev_mode <= 1'b0;
              end else if (!id_mode) begin
                if (code == CD_IDENT) begin
                  id_mode <= 1'b1;
                  id_bank <= wr_hi;
                end else if (code == CD_PROG) begin
                  st <= SQ_PGM;
                end else if (code == CD_ERASE) begin
                  st <= SQ_E3;
                end
              end
            end
          end
          SQ_PGM: begin
            op_valid <= 1'b1;
            op_kind  <= OP_PROG;
            op_bank  <= wr_hi;
            op_addr  <= wr_addr;
            op_data  <= byte_mode ? {{(DATA_W-8){1'b0}}, wr_data[7:0]} : wr_data;
          end
          SQ_E3: if (hit_k1 && code == CD_KEY1) st <= SQ_E4;
          SQ_E4: if (hit_k2 && code == CD_KEY2) st <= SQ_E5;
          SQ_E5: begin
            op_bank <= wr_hi;
            op_data <= '0;
            case (code)
              CD_SECT: begin
                op_valid <= 1'b1;
                op_kind  <= OP_SECT;
                op_addr  <= {wr_addr[ADDR_W-1:SECT_LSB], {SECT_LSB{1'b0}}};
              end
              CD_BLK: begin
                op_valid <= 1'b1;
                op_kind  <= OP_BLK;
                op_addr  <= {wr_addr[ADDR_W-1:BLK_LSB], {BLK_LSB{1'b0}}};
              end
              CD_CHIP: if (hit_k1) begin
                op_valid <= 1'b1;
                op_kind  <= OP_CHIP;
                op_addr  <= {{2{wr_hi}}, {BANK_LSB{1'b0}}};
              end
              CD_VFY: if (hit_k1) ev_mode <= 1'b1;
              default: ;
            endcase
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/cmdseq_idrom.sv
`timescale 1ns/1ps
module cmdseq_idrom #(
  parameter int          ADDR_W = 20,
  parameter int          DATA_W = 16,
  parameter logic [15:0] MAKER  = 16'h0062,
  parameter logic [15:0] DEV_HI = 16'h257E,
  parameter logic [15:0] DEV_LO = 16'h257D
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              id_mode,
  input  logic              id_bank,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] id_word
);
  localparam int BANK_LSB = ADDR_W - 2;

  logic                rd_hi;
  logic [BANK_LSB-1:0] off;

  assign rd_hi = &rd_addr[ADDR_W-1:BANK_LSB];
  assign off   = rd_addr[BANK_LSB-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      id_word <= '0;
    end else begin
      id_word <= '0;
      if (id_mode && rd_hi == id_bank) begin
        if (off == '0)
          id_word <= DATA_W'(MAKER);
        else if (off == BANK_LSB'(1))
          id_word <= id_bank ? DATA_W'(DEV_HI) : DATA_W'(DEV_LO);
      end
    end
  end
endmodule

// File: rtl/cmdseq_decoder.sv
`timescale 1ns/1ps
module cmdseq_decoder #(
  parameter int ADDR_W   = 20,
  parameter int DATA_W   = 16,
  parameter int CMD_AW   = 15,
  parameter int SECT_LSB = 10,
  parameter int BLK_LSB  = 15,
  parameter int N_BANK   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_stb,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [N_BANK-1:0] bank_busy,
  input  logic              byte_mode,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              op_valid,
  output logic [1:0]        op_kind,
  output logic              op_bank,
  output logic [ADDR_W-1:0] op_addr,
  output logic [DATA_W-1:0] op_data,
  output logic              id_mode,
  output logic              id_bank,
  output logic              ev_mode,
  output logic [DATA_W-1:0] id_word
);
  import cmdseq_pkg::*;

  logic     hit_k1, hit_k2;
  op_kind_t kind_q;

  cmdseq_match #(.CMD_AW(CMD_AW)) i_match (
    .addr_lo (wr_addr[CMD_AW-1:0]),
    .hit_k1  (hit_k1),
    .hit_k2  (hit_k2)
  );

  cmdseq_fsm #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SECT_LSB(SECT_LSB), .BLK_LSB(BLK_LSB)
  ) i_fsm (
    .clk       (clk),
    .rst       (rst),
    .wr_stb    (wr_stb),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .hit_k1    (hit_k1),
    .hit_k2    (hit_k2),
    .busy_any  (|bank_busy),
    .byte_mode (byte_mode),
    .op_valid  (op_valid),
    .op_kind   (kind_q),
    .op_bank   (op_bank),
    .op_addr   (op_addr),
    .op_data   (op_data),
    .id_mode   (id_mode),
    .id_bank   (id_bank),
    .ev_mode   (ev_mode)
  );

  assign op_kind = kind_q;

  cmdseq_idrom #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_idrom (
    .clk     (clk),
    .rst     (rst),
    .id_mode (id_mode),
    .id_bank (id_bank),
    .rd_addr (rd_addr),
    .id_word (id_word)
  );
endmodule

// File: rtl/cmdseq_decoder_chk.sv
`timescale 1ns/1ps
module cmdseq_decoder_chk #(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16,
  parameter int N_BANK = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_stb,
  input logic [7:0]        wr_code,
  input logic [N_BANK-1:0] bank_busy,
  input logic              byte_mode,
  input logic              op_valid,
  input logic [1:0]        op_kind,
  input logic [ADDR_W-3:0] op_addr_lo,
  input logic [DATA_W-9:0] op_hi,
  input logic              id_mode,
  input logic              ev_mode
);
  p_src_r2: assert property (@(posedge clk) disable iff (rst)
    op_valid |-> ($past(wr_stb) && !$past(|bank_busy)));

  p_chip_base_r3: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_kind == 2'd3) |-> (op_addr_lo == '0));

  p_busy_noop_r6: assert property (@(posedge clk) disable iff (rst)
    (wr_stb && |bank_busy) |=> (!op_valid && $stable(id_mode) && $stable(ev_mode)));

  p_id_enter_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(id_mode) |-> ($past(wr_stb) && $past(wr_code) == 8'h90));

  p_id_exit_r7: assert property (@(posedge clk) disable iff (rst)
    $fell(id_mode) |-> ($past(wr_code) == 8'hF0));

  p_id_block_r8: assert property (@(posedge clk) disable iff (rst)
    id_mode |=> !op_valid);

  p_ev_enter_r10: assert property (@(posedge clk) disable iff (rst)
    $rose(ev_mode) |-> ($past(wr_code) == 8'hB0));

  p_byte_data_r11: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_kind == 2'd0 && $past(byte_mode)) |-> (op_hi == '0));

  p_pulse_r12: assert property (@(posedge clk) disable iff (rst)
    op_valid |=> !op_valid);
endmodule

bind cmdseq_decoder cmdseq_decoder_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .N_BANK(N_BANK)
) i_chk (
  .clk        (clk),
  .rst        (rst),
  .wr_stb     (wr_stb),
  .wr_code    (wr_data[7:0]),
  .bank_busy  (bank_busy),
  .byte_mode  (byte_mode),
  .op_valid   (op_valid),
  .op_kind    (op_kind),
  .op_addr_lo (op_addr[ADDR_W-3:0]),
  .op_hi      (op_data[DATA_W-1:8]),
  .id_mode    (id_mode),
  .ev_mode    (ev_mode)
);

// File: tb/test_cmdseq_decoder.sv
`timescale 1ns/1ps
module test_cmdseq_decoder;
  localparam int AW = 20;
  localparam int DW = 16;

  typedef struct packed {
    logic [3:0]  req;
    logic [19:0] a;
    logic [15:0] d;
    logic        bm;
    logic        v;
    logic [1:0]  k;
    logic        b;
    logic [19:0] ea;
    logic [15:0] ed;
    logic        eid;
    logic        eev;
  } vec_t;

  function automatic vec_t mk(input int r, input logic [19:0] a, input logic [15:0] d,
                              input bit bm, input bit v, input logic [1:0] k, input bit b,
                              input logic [19:0] ea, input logic [15:0] ed,
                              input bit eid, input bit eev);
    return '{req: 4'(r), a: a, d: d, bm: bm, v: v, k: k, b: b, ea: ea, ed: ed, eid: eid, eev: eev};
  endfunction

  function automatic vec_t nz(input int r, input logic [19:0] a, input logic [15:0] d,
                              input bit eid, input bit eev);
    return mk(r, a, d, 1'b0, 1'b0, 2'd0, 1'b0, 20'h0, 16'h0, eid, eev);
  endfunction

  localparam int NV = 62;
  localparam vec_t VT [NV] = '{
    // R2 program, lower bank
    nz(2, 20'h05555, 16'h00AA, 0, 0), nz(2, 20'h02AAA, 16'h0055, 0, 0),
    nz(2, 20'h05555, 16'h00A0, 0, 0),
    mk(2, 20'h12345, 16'hBEEF, 0, 1, 2'd0, 0, 20'h12345, 16'hBEEF, 0, 0),
    // R3 sector erase, upper bank
    nz(3, 20'h05555, 16'h00AA, 0, 0), nz(3, 20'h02AAA, 16'h0055, 0, 0),
    nz(3, 20'h05555, 16'h0080, 0, 0), nz(3, 20'h05555, 16'h00AA, 0, 0),
    nz(3, 20'h02AAA, 16'h0055, 0, 0),
    mk(3, 20'hC37FF, 16'h0030, 0, 1, 2'd1, 1, 20'hC3400, 16'h0000, 0, 0),
    // R3 block erase, lower bank
    nz(3, 20'h05555, 16'h00AA, 0, 0), nz(3, 20'h02AAA, 16'h0055, 0, 0),
    nz(3, 20'h05555, 16'h0080, 0, 0), nz(3, 20'h05555, 16'h00AA, 0, 0),
    nz(3, 20'h02AAA, 16'h0055, 0, 0),
    mk(3, 20'h4ABCD, 16'h0050, 0, 1, 2'd2, 0, 20'h48000, 16'h0000, 0, 0),
    // R4 chip erase upper bank with noise in A17..A15 and DQ15..DQ8
    nz(4, 20'h3D555, 16'hFFAA, 0, 0), nz(4, 20'h0AAAA, 16'h1255, 0, 0),
    nz(4, 20'h25555, 16'hAB80, 0, 0), nz(4, 20'h1D555, 16'h00AA, 0, 0),
    nz(4, 20'h32AAA, 16'hC355, 0, 0),
    mk(4, 20'hFD555, 16'h7710, 0, 1, 2'd3, 1, 20'hC0000, 16'h0000, 0, 0),
    // R5 chip erase with wrong address: dropped
    nz(5, 20'h05555, 16'h00AA, 0, 0), nz(5, 20'h02AAA, 16'h0055, 0, 0),
    nz(5, 20'h05555, 16'h0080, 0, 0), nz(5, 20'h05555, 16'h00AA, 0, 0),
    nz(5, 20'h02AAA, 16'h0055, 0, 0), nz(5, 20'hC5554, 16'h0010, 0, 0),
    // R5 wrong data at step two, then no silent resume
    nz(5, 20'h05555, 16'h00AA, 0, 0), nz(5, 20'h02AAA, 16'h0056, 0, 0),
    nz(5, 20'h02AAA, 16'h0055, 0, 0), nz(5, 20'h05555, 16'h00A0, 0, 0),
    nz(5, 20'h00001, 16'h0001, 0, 0),
    // R11 byte-mode program
    mk(11, 20'h05555, 16'h00AA, 1, 0, 2'd0, 0, 20'h0, 16'h0, 0, 0),
    mk(11, 20'h02AAA, 16'h0055, 1, 0, 2'd0, 0, 20'h0, 16'h0, 0, 0),
    mk(11, 20'h05555, 16'h00A0, 1, 0, 2'd0, 0, 20'h0, 16'h0, 0, 0),
    mk(11, 20'h00100, 16'hABCD, 1, 1, 2'd0, 0, 20'h00100, 16'h00CD, 0, 0),
    // R7 identification entry on upper bank
    nz(7, 20'h05555, 16'h00AA, 0, 0), nz(7, 20'h02AAA, 16'h0055, 0, 0),
    nz(7, 20'hC5555, 16'h0090, 1, 0),
    // R8 program attempt in identification mode
    nz(8, 20'h05555, 16'h00AA, 1, 0), nz(8, 20'h02AAA, 16'h0055, 1, 0),
    nz(8, 20'h05555, 16'h00A0, 1, 0), nz(8, 20'h00200, 16'h1111, 1, 0),
    // R7 exit
    nz(7, 20'h05555, 16'h00AA, 1, 0), nz(7, 20'h02AAA, 16'h0055, 1, 0),
    nz(7, 20'h05555, 16'h00F0, 0, 0),
    // R10 erase-verify entry
    nz(10, 20'h05555, 16'h00AA, 0, 0), nz(10, 20'h02AAA, 16'h0055, 0, 0),
    nz(10, 20'h05555, 16'h0080, 0, 0), nz(10, 20'h05555, 16'h00AA, 0, 0),
    nz(10, 20'h02AAA, 16'h0055, 0, 0), nz(10, 20'h05555, 16'h00B0, 0, 1),
    // R10 sector erase allowed in erase-verify mode
    nz(10, 20'h05555, 16'h00AA, 0, 1), nz(10, 20'h02AAA, 16'h0055, 0, 1),
    nz(10, 20'h05555, 16'h0080, 0, 1), nz(10, 20'h05555, 16'h00AA, 0, 1),
    nz(10, 20'h02AAA, 16'h0055, 0, 1),
    mk(10, 20'h00400, 16'h0030, 0, 1, 2'd1, 0, 20'h00400, 16'h0000, 0, 1),
    // R7 exit clears erase-verify too
    nz(7, 20'h05555, 16'h00AA, 0, 1), nz(7, 20'h02AAA, 16'h0055, 0, 1),
    nz(7, 20'hC5555, 16'h00F0, 0, 0)
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_stb = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [1:0]    bank_busy = 2'b00;
  logic          byte_mode = 1'b0;
  logic [AW-1:0] rd_addr = '0;
  logic          op_valid;
  logic [1:0]    op_kind;
  logic          op_bank;
  logic [AW-1:0] op_addr;
  logic [DW-1:0] op_data;
  logic          id_mode, id_bank, ev_mode;
  logic [DW-1:0] id_word;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #2 clk = ~clk; // 250 MHz

  cmdseq_decoder i_cmdseq_decoder (
    .clk(clk), .rst(rst), .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
    .bank_busy(bank_busy), .byte_mode(byte_mode), .rd_addr(rd_addr),
    .op_valid(op_valid), .op_kind(op_kind), .op_bank(op_bank), .op_addr(op_addr),
    .op_data(op_data), .id_mode(id_mode), .id_bank(id_bank), .ev_mode(ev_mode),
    .id_word(id_word)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic strobe(input logic [19:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_addr = a;
    wr_data = d;
    wr_stb  = 1'b1;
    @(negedge clk);
    wr_stb  = 1'b0;
  endtask

  task automatic read_id(input logic [19:0] a, input logic [15:0] exp, input string req);
    @(negedge clk);
    rd_addr = a;
    @(negedge clk);
    check(id_word == exp, req, 64'(id_word), 64'(exp));
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check({op_valid, id_mode, ev_mode} == 3'b000 && id_word == '0, "R1",
          64'({op_valid, id_mode, ev_mode, id_word}), 64'(0));

    // table walk
    for (int i = 0; i < NV; i++) begin
      byte_mode = VT[i].bm;
      strobe(VT[i].a, VT[i].d);
      if (VT[i].v)
        check(op_valid && op_kind == VT[i].k && op_bank == VT[i].b && op_addr == VT[i].ea &&
              op_data == VT[i].ed && id_mode == VT[i].eid && ev_mode == VT[i].eev,
              $sformatf("R%0d vec%0d", VT[i].req, i),
              {op_valid, op_kind, op_bank, op_addr, op_data, id_mode, ev_mode},
              {1'b1, VT[i].k, VT[i].b, VT[i].ea, VT[i].ed, VT[i].eid, VT[i].eev});
      else
        check(!op_valid && id_mode == VT[i].eid && ev_mode == VT[i].eev,
              $sformatf("R%0d vec%0d", VT[i].req, i),
              64'({op_valid, id_mode, ev_mode}), 64'({1'b0, VT[i].eid, VT[i].eev}));
      if (VT[i].v) begin
        @(negedge clk);
        check(!op_valid, "R12 pulse", 64'(op_valid), 64'(0));
      end
    end
    byte_mode = 1'b0;

    // R6 busy holds position and blocks requests
    strobe(20'h05555, 16'h00AA);
    strobe(20'h02AAA, 16'h0055);
    bank_busy = 2'b01;
    strobe(20'h05555, 16'h00A0);
    strobe(20'h00005, 16'h0000);
    check(!op_valid, "R6 busy", 64'(op_valid), 64'(0));
    bank_busy = 2'b10;
    strobe(20'h05555, 16'h0090);
    check(!id_mode, "R6 busy mode", 64'(id_mode), 64'(0));
    bank_busy = 2'b00;
    strobe(20'h05555, 16'h00A0);
    strobe(20'h00300, 16'h5A5A);
    check(op_valid && op_addr == 20'h00300 && op_data == 16'h5A5A, "R6 resume",
          64'({op_valid, op_addr, op_data}), {1'b1, 20'h00300, 16'h5A5A});

    // R9 identification words, upper bank
    read_id(20'hC0000, 16'h0000, "R9 off");
    strobe(20'h05555, 16'h00AA);
    strobe(20'h02AAA, 16'h0055);
    strobe(20'hC5555, 16'h0090);
    check(id_mode && id_bank, "R7 id bank hi", 64'({id_mode, id_bank}), 64'(3));
    read_id(20'hC0000, 16'h0062, "R9 maker");
    read_id(20'hC0001, 16'h257E, "R9 dev hi");
    read_id(20'h00000, 16'h0000, "R9 other bank");
    read_id(20'hC0002, 16'h0000, "R9 offset2");
    strobe(20'h05555, 16'h00AA);
    strobe(20'h02AAA, 16'h0055);
    strobe(20'h05555, 16'h00F0);
    read_id(20'hC0000, 16'h0000, "R9 after exit");

    // R9 lower bank identification
    strobe(20'h05555, 16'h00AA);
    strobe(20'h02AAA, 16'h0055);
    strobe(20'h45555, 16'h0090);
    check(id_mode && !id_bank, "R7 id bank lo", 64'({id_mode, id_bank}), 64'(2));
    read_id(20'h00001, 16'h257D, "R9 dev lo");
    strobe(20'h05555, 16'h00AA);
    strobe(20'h02AAA, 16'h0055);
    strobe(20'h05555, 16'h00F0);

    // R10 erase-verify entry needs 5555h in the sixth cycle
    strobe(20'h05555, 16'h00AA);
    strobe(20'h02AAA, 16'h0055);
    strobe(20'h05555, 16'h0080);
    strobe(20'h05555, 16'h00AA);
    strobe(20'h02AAA, 16'h0055);
    strobe(20'h01234, 16'h00B0);
    check(!ev_mode, "R10 bad addr", 64'(ev_mode), 64'(0));

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule